// File: doc/BRIEF.md
# Folded Thermometer-to-Binary Encoder for a 5-bit Flash Converter

This block turns the 32 comparator outputs of a 5-bit flash converter into a 5-bit binary count. It uses no priority encoder or lookup. A first stage folds the comparator vector into nine intermediate lines. Each of the first eight lines pairs a tap with the taps 8, 16 and 24 positions above it. The ninth line marks the upper half of the range. A second stage turns those lines into binary: the upper two bits are taken directly from two of the lines, and the lower three bits are ORs of XORs over the lines.

The comparator vector is encoded in the same cycle it is sampled. The result is captured in an output register on the next rising clock edge. Comparator bit 0 is the lowest threshold, so a reading of k has bits 0 through k-1 high. When all 32 comparators are high, the code wraps to zero; no saturation logic is added. Inputs that break the thermometer pattern (bubbles) still produce a defined code, and that code depends only on the vector sampled in the same cycle.

Top module: `fte_encoder`

## Requirements
- R1: For a thermometer input with k ones in the low positions (cmp_taps[k-1:0] high, the rest low), with k from 0 to 31, code equals k after the next rising clock edge.
- R2: While rst_n is low, code is 0. The reset acts asynchronously and is held across clock edges.
- R3: code updates only on a rising clock edge. An input change between edges leaves code unchanged until the next edge.
- R4: With all 32 comparator bits high, code becomes 0 after the next edge (wraparound, no saturation).
- R5: code after an edge depends only on the comparator vector sampled at that edge. The same vector gives the same code whatever inputs came before it.
- R6: Any fully driven input, including vectors with bubbles, yields a code with no unknown bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| cmp_taps | input | 32 | Comparator outputs; bit 0 is the lowest threshold |
| code | output | 5 | Registered binary result |

## Verification
A wrong fold line would not upset every output. It would give a bad code only for the thermometer readings that cross the bad tap pair, and it would show one edge after such a reading is applied. For that reason all 33 thermometer levels are walked, both upward and downward. Because the block keeps no state apart from its output register, any stale value shows within a single edge. It appears as a code that differs when the same vector is applied after different predecessors, or as a code that changes before the clock edge.

// File: rtl/fte_pkg.sv
package fte_pkg;
  // Fold period: the number of fold lines that feed the low bits.
  function automatic int fold_len(input int bits);
    return 2 ** (bits - 2);
  endfunction

  // The number of comparator taps for a given output width.
  function automatic int tap_count(input int bits);
    return 2 ** bits;
  endfunction
endpackage

// File: rtl/fte_fold.sv
module fte_fold
  import fte_pkg::*;
#(
  parameter int BITS = 5
) (
  input  logic [tap_count(BITS)-1:0] taps,
  output logic [fold_len(BITS):0]    fold
);
  localparam int F = fold_len(BITS);

  // Line n (0-based) is high in the windows [n+1, n+F] and [n+2F+1, n+3F] of the count.
  for (genvar n = 0; n < F; n++) begin : g_line
    always_comb begin
      fold[n] = (taps[n] & ~taps[n+F]) | (taps[n+2*F] & ~taps[n+3*F]);
    end
  end

  // Upper-half line: a count from 2F up to 4F-1.
  always_comb begin
    fold[F] = (taps[2*F-1] | taps[2*F]) & ~taps[4*F-1];
  end
endmodule

// File: rtl/fte_binmap.sv
module fte_binmap
  import fte_pkg::*;
#(
  parameter int BITS = 5
) (
  input  logic [fold_len(BITS):0] fold,
  output logic [BITS-1:0]         bin
);
  localparam int F = fold_len(BITS);

  // Low bits: the OR of XORs over fold-line pairs spaced 2^j apart.
  for (genvar j = 0; j < BITS - 2; j++) begin : g_bit
    localparam int STEP  = 2 ** j;
    localparam int PAIRS = F / (2 * STEP);
    logic [PAIRS-1:0] diff;
    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
      always_comb begin
        diff[i] = fold[STEP*(2*i+1)-1] ^ fold[STEP*(2*i+2)-1];
      end
    end
    always_comb begin
      bin[j] = |diff;
    end
  end

  always_comb begin
    bin[BITS-2] = fold[F-1];
    bin[BITS-1] = fold[F];
  end
endmodule

// File: rtl/fte_outreg.sv
module fte_outreg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/fte_encoder.sv
module fte_encoder
  import fte_pkg::*;
#(
  parameter int BITS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [tap_count(BITS)-1:0] cmp_taps,
  output logic [BITS-1:0]            code
);
  localparam int F = fold_len(BITS);

  logic [F:0]      fold_w;
  logic [BITS-1:0] bin_w;

  fte_fold #(.BITS(BITS)) u_fold (
    .taps (cmp_taps),
    .fold (fold_w)
  );

  fte_binmap #(.BITS(BITS)) u_map (
    .fold (fold_w),
    .bin  (bin_w)
  );

  fte_outreg #(.W(BITS)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bin_w),
    .q     (code)
  );
endmodule

// File: rtl/fte_encoder_chk.sv
module fte_encoder_chk
  import fte_pkg::*;
#(
  parameter int BITS = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [tap_count(BITS)-1:0] cmp_taps,
  input logic [BITS-1:0]            code
);
  localparam int TAPS = tap_count(BITS);

  function automatic logic is_therm(input logic [TAPS-1:0] v);
    return ((v & (v + 1'b1)) == '0);
  endfunction

  // R1 / R4: a thermometer input becomes its count modulo 2^BITS one edge later.
  p_therm_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_therm(cmp_taps) |=> code == BITS'($countones($past(cmp_taps))));

  // R4: all comparators high wraps to zero.
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&cmp_taps) |=> code == '0);

  // R5: no hidden history; a steady input keeps the code steady.
  p_memoryless_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(cmp_taps)) |=> $stable(code));

  // R2: the output is cleared while reset is held.
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_clear_r2: assert (code == '0);
    end
  end
endmodule

bind fte_encoder fte_encoder_chk #(.BITS(BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmp_taps (cmp_taps),
  .code     (code)
);

// File: tb/sim_fte_encoder.sv
`timescale 1ns/1ps
module sim_fte_encoder;
  localparam int   BITS = 5;
  localparam int   TAPS = 32;
  localparam time  TCK  = 20ns;

  typedef struct packed {
    logic [TAPS-1:0] stim;
    logic [BITS-1:0] expv;
  } vec_t;

  localparam vec_t TABLE [33] = '{
    '{32'h0000_0000, 5'd0},  '{32'h0000_0001, 5'd1},  '{32'h0000_0003, 5'd2},
    '{32'h0000_0007, 5'd3},  '{32'h0000_000F, 5'd4},  '{32'h0000_001F, 5'd5},
    '{32'h0000_003F, 5'd6},  '{32'h0000_007F, 5'd7},  '{32'h0000_00FF, 5'd8},
    '{32'h0000_01FF, 5'd9},  '{32'h0000_03FF, 5'd10}, '{32'h0000_07FF, 5'd11},
    '{32'h0000_0FFF, 5'd12}, '{32'h0000_1FFF, 5'd13}, '{32'h0000_3FFF, 5'd14},
    '{32'h0000_7FFF, 5'd15}, '{32'h0000_FFFF, 5'd16}, '{32'h0001_FFFF, 5'd17},
    '{32'h0003_FFFF, 5'd18}, '{32'h0007_FFFF, 5'd19}, '{32'h000F_FFFF, 5'd20},
    '{32'h001F_FFFF, 5'd21}, '{32'h003F_FFFF, 5'd22}, '{32'h007F_FFFF, 5'd23},
    '{32'h00FF_FFFF, 5'd24}, '{32'h01FF_FFFF, 5'd25}, '{32'h03FF_FFFF, 5'd26},
    '{32'h07FF_FFFF, 5'd27}, '{32'h0FFF_FFFF, 5'd28}, '{32'h1FFF_FFFF, 5'd29},
    '{32'h3FFF_FFFF, 5'd30}, '{32'h7FFF_FFFF, 5'd31}, '{32'hFFFF_FFFF, 5'd0}
  };

  logic            clk;
  logic            rst_n;
  logic [TAPS-1:0] cmp_taps;
  logic [BITS-1:0] code;

  int n_chk;
  int n_bad;
  bit done;

  fte_encoder #(.BITS(BITS)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_taps (cmp_taps),
    .code     (code)
  );

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  function automatic logic [BITS-1:0] ref_count(input logic [TAPS-1:0] v);
    int c = 0;
    for (int i = 0; i < TAPS; i++) c += int'(v[i]);
    return BITS'(c);
  endfunction

  task automatic check(input string req, input logic [BITS-1:0] act,
                       input logic [BITS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: code=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at the falling edge; the result is read at the following falling edge.
  task automatic apply(input logic [TAPS-1:0] v, output logic [BITS-1:0] got);
    @(negedge clk);
    cmp_taps = v;
    @(negedge clk);
    got = code;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: code=%0d expected=completion", code);
    finish_up();
  end

  initial begin
    logic [BITS-1:0] got, r_a, r_b;
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    cmp_taps = 32'h0000_7FFF;
    repeat (3) @(negedge clk);
    check("R2 reset state", code, 5'd0);
    rst_n = 1'b1;

    // R1 and R4: upward walk of every level, checked against the table and a ones-count model
    for (int k = 0; k < 33; k++) begin
      apply(TABLE[k].stim, got);
      check("R1 table", got, TABLE[k].expv);
      check((k == 32) ? "R4 wraparound" : "R1 ones count", got, ref_count(TABLE[k].stim));
    end
    // downward walk
    for (int k = 31; k >= 0; k--) begin
      apply(TABLE[k].stim, got);
      check("R1 downward", got, TABLE[k].expv);
    end

    // R3: an input change between edges does not reach the output early
    apply(TABLE[20].stim, got);
    @(negedge clk);
    cmp_taps = TABLE[9].stim;
    #(TCK/4);
    check("R3 before edge", code, 5'd20);
    @(negedge clk);
    check("R3 after edge", code, 5'd9);

    // R5: a bubbled vector gives the same code after different predecessors
    apply(TABLE[0].stim, got);
    apply(32'h0000_00F7, r_a);
    apply(TABLE[31].stim, got);
    apply(32'h0000_00F7, r_b);
    check("R5 repeat bubble", r_b, r_a);
    apply(32'h0001_FBFF, r_a);
    apply(TABLE[16].stim, got);
    apply(32'h0001_FBFF, r_b);
    check("R5 repeat bubble 2", r_b, r_a);

    // R6: bubble vectors give defined codes (values are recorded only)
    begin
      logic [TAPS-1:0] bub [4] = '{32'h0000_00F7, 32'h0001_FBFF, 32'h0FFF_7FFF, 32'hFFFE_FFFF};
      for (int b = 0; b < 4; b++) begin
        apply(bub[b], got);
        $display("bubble %h -> code %0d", bub[b], got);
        n_chk++;
        if ((^got) === 1'bx) begin
          n_bad++;
          $display("FAIL R6: code=%b expected=defined bits", got);
        end
      end
    end

    // R2: an asynchronous reset in mid-run clears the output and holds it
    apply(TABLE[27].stim, got);
    check("R1 before reset", got, 5'd27);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R2 async clear", code, 5'd0);
    @(negedge clk);
    check("R2 held over edge", code, 5'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", code, 5'd27);

    finish_up();
  end
endmodule